// File: doc/BRIEF.md
# Dual-Port Block RAM with Per-Port Aspect Ratio

This block is an 18 Kbit true dual-port RAM. Two fully independent ports share one storage body of 16 Kbit of data plus 2 Kbit of parity. Each port picks its own word shape at elaboration time. It can be 36, 18 or 9 bits wide, with parity lanes, or 4, 2 or 1 bit wide, with data only. Both ports see the same bits, so a word written through a wide port can be read back through a narrow port, and the reverse also holds.

Each port has its own clock, enable, write enable, output reset, address, write data and read data. Static parameters set, separately for each port, which clock edge is active and whether each of the three controls is active high or active low. Reads are synchronous and go through an output register. A write shows the new word on the same port's output in the same cycle.

Top module: `dual_aspect_bram`

## Requirements
- R1: Data bits form one linear 16384-bit array. A port whose data part is DB bits wide sees address `n` as array bits `[n*DB +: DB]`. Either port can read a word that the other port wrote.
- R2: In the 36-, 18- and 9-bit shapes the write and read buses carry data in bits `[DB-1:0]` and parity in the bits above. DB is 32, 16 or 8, and PB is 4, 2 or 1. Parity lives in a separate 2048-bit array, where address `n` maps to bits `[n*PB +: PB]`.
- R3: Each port's width parameter (36, 18, 9, 4, 2 or 1) is chosen independently of the other port. Its address bus is log2(16384/DB) bits wide.
- R4: When reset is at its active level on an active clock edge, that port's read data becomes zero, whatever the enable level. Memory contents are not changed by reset.
- R5: When enable is at its inactive level, the port performs neither a read nor a write, and its read data holds its previous value.
- R6: An enabled write with no reset drives the written word (data and parity) on that port's read data after the same active edge (write-first).
- R7: Each port updates only on its chosen clock edge, rising or falling. The default port B uses the falling edge, and its read data is unchanged across the rising edge that comes before it.
- R8: The active level of enable, write enable and reset is a per-port parameter. The default port B uses active-low enable and write enable and an active-high reset. A write enable at its inactive level turns an access into a read.
- R9: A read with enable active and no write returns the word at the applied address one active edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A enable (polarity by parameter) |
| a_we | input | 1 | Port A write enable (polarity by parameter) |
| a_rst | input | 1 | Port A output-register reset (polarity by parameter) |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_WIDTH | Port A write word, parity above data |
| a_rdata | output | A_WIDTH | Port A registered read word |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B enable (polarity by parameter) |
| b_we | input | 1 | Port B write enable (polarity by parameter) |
| b_rst | input | 1 | Port B output-register reset (polarity by parameter) |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_WIDTH | Port B write word, parity above data |
| b_rdata | output | B_WIDTH | Port B registered read word |

## Verification
A lane offset or row index computed wrongly places bits in the wrong spot of the shared array. It shows up only when the other port, with its different shape, reads that region. That is one active edge of the reading port after the address is applied. The bench therefore fills the whole array through one port and reads every address back through the other, in both directions, so any misrouted data or parity bit shows up within the sweep. A wrong enable, polarity or edge choice shows on the very next active edge as a changed or unchanged read word.

// File: rtl/bram_cfg_pkg.sv
package bram_cfg_pkg;
    // Storage is kept as rows of 32 data bits plus 4 parity bits.
    localparam int ROWS       = 512;
    localparam int ROW_DBITS  = 32;
    localparam int ROW_PBITS  = 4;
    localparam int ROW_BITS   = ROW_DBITS + ROW_PBITS;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int DATA_TOTAL = ROWS * ROW_DBITS;

    typedef logic [ROW_BITS-1:0] row_t;

    // Data part of a port word: 36->32, 18->16, 9->8, narrow shapes unchanged.
    function automatic int data_bits(input int width);
        return (width >= 9) ? (width / 9) * 8 : width;
    endfunction

    function automatic int parity_bits(input int width);
        return width - data_bits(width);
    endfunction
endpackage

// File: rtl/bram_lane_decode.sv
module bram_lane_decode
    import bram_cfg_pkg::*;
#(
    parameter int AW    = 9,
    parameter int LANES = 1,
    parameter int DB    = 32,
    parameter int PB    = 4
) (
    input  logic [AW-1:0]     addr,
    output logic [ROW_AW-1:0] row,
    output logic [4:0]        doff,
    output logic [1:0]        poff
);
    int lane;

    always_comb begin
        lane = int'(addr) % LANES;
        row  = ROW_AW'(int'(addr) / LANES);
        doff = 5'(lane * DB);
        poff = 2'(lane * PB);
    end
endmodule

// File: rtl/bram_port.sv
module bram_port
    import bram_cfg_pkg::*;
#(
    parameter int WIDTH    = 36,
    parameter bit RISE     = 1'b1,
    parameter bit WE_HIGH  = 1'b1,
    parameter bit EN_HIGH  = 1'b1,
    parameter bit RST_HIGH = 1'b1,
    localparam int DB      = data_bits(WIDTH),
    localparam int PB      = parity_bits(WIDTH),
    localparam int PBW     = (PB > 0) ? PB : 1,
    localparam int LANES   = ROW_DBITS / DB,
    localparam int AW      = $clog2(DATA_TOTAL / DB)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  row_t             peer_mem [ROWS],
    output row_t             own_mem  [ROWS]
);
    typedef struct packed {
        logic [WIDTH-1:0]  rdata;
        logic              wr;
        logic [ROW_AW-1:0] row;
        row_t              wrow;
    } port_state_t;

    logic              clk_act;
    logic [ROW_AW-1:0] row;
    logic [4:0]        doff;
    logic [1:0]        poff;
    logic              en_on, we_on, rst_on;
    logic [PBW-1:0]    wpar;
    row_t              cur, merged, src;
    logic [DB+PBW-1:0] full;
    logic [WIDTH-1:0]  rdata_q;
    row_t              own_q [ROWS];
    port_state_t       st_d;

    generate
        if (RISE) begin : g_rise
            assign clk_act = clk;
        end else begin : g_fall
            assign clk_act = ~clk;
        end
    endgenerate

    bram_lane_decode #(.AW(AW), .LANES(LANES), .DB(DB), .PB(PB)) i_decode (
        .addr (addr),
        .row  (row),
        .doff (doff),
        .poff (poff)
    );

    always_comb begin
        en_on  = (en == EN_HIGH);
        we_on  = (we == WE_HIGH);
        rst_on = (rst == RST_HIGH);
        wpar   = PBW'(wdata >> DB);
        // Live row value is the XOR of both ports' private copies.
        cur    = own_q[row] ^ peer_mem[row];
        merged = cur;
        merged[doff +: DB] = wdata[DB-1:0];
        if (PB > 0) merged[ROW_DBITS + int'(poff) +: PBW] = wpar;
        src  = (we_on) ? merged : cur;
        full = {src[ROW_DBITS + int'(poff) +: PBW], src[doff +: DB]};

        st_d.rdata = rdata_q;
        st_d.wr    = 1'b0;
        st_d.row   = row;
        st_d.wrow  = merged ^ peer_mem[row];
        if (en_on) begin
            st_d.wr    = we_on;
            st_d.rdata = full[WIDTH-1:0];
        end
        if (rst_on) st_d.rdata = '0;
    end

    always_ff @(posedge clk_act) begin
        rdata_q <= st_d.rdata;
        if (st_d.wr) own_q[st_d.row] <= st_d.wrow;
    end

    assign rdata   = rdata_q;
    assign own_mem = own_q;
endmodule

// File: rtl/dual_aspect_bram.sv
module dual_aspect_bram
    import bram_cfg_pkg::*;
#(
    parameter int A_WIDTH    = 36,
    parameter bit A_RISE     = 1'b1,
    parameter bit A_WE_HIGH  = 1'b1,
    parameter bit A_EN_HIGH  = 1'b1,
    parameter bit A_RST_HIGH = 1'b1,
    parameter int B_WIDTH    = 9,
    parameter bit B_RISE     = 1'b0,
    parameter bit B_WE_HIGH  = 1'b0,
    parameter bit B_EN_HIGH  = 1'b0,
    parameter bit B_RST_HIGH = 1'b1,
    localparam int A_AW      = $clog2(DATA_TOTAL / data_bits(A_WIDTH)),
    localparam int B_AW      = $clog2(DATA_TOTAL / data_bits(B_WIDTH))
) (
    input  logic               a_clk,
    input  logic               a_en,
    input  logic               a_we,
    input  logic               a_rst,
    input  logic [A_AW-1:0]    a_addr,
    input  logic [A_WIDTH-1:0] a_wdata,
    output logic [A_WIDTH-1:0] a_rdata,
    input  logic               b_clk,
    input  logic               b_en,
    input  logic               b_we,
    input  logic               b_rst,
    input  logic [B_AW-1:0]    b_addr,
    input  logic [B_WIDTH-1:0] b_wdata,
    output logic [B_WIDTH-1:0] b_rdata
);
    row_t mem_a [ROWS];
    row_t mem_b [ROWS];

    bram_port #(
        .WIDTH(A_WIDTH), .RISE(A_RISE), .WE_HIGH(A_WE_HIGH),
        .EN_HIGH(A_EN_HIGH), .RST_HIGH(A_RST_HIGH)
    ) i_port_a (
        .clk(a_clk), .en(a_en), .we(a_we), .rst(a_rst), .addr(a_addr),
        .wdata(a_wdata), .rdata(a_rdata), .peer_mem(mem_b), .own_mem(mem_a)
    );

    bram_port #(
        .WIDTH(B_WIDTH), .RISE(B_RISE), .WE_HIGH(B_WE_HIGH),
        .EN_HIGH(B_EN_HIGH), .RST_HIGH(B_RST_HIGH)
    ) i_port_b (
        .clk(b_clk), .en(b_en), .we(b_we), .rst(b_rst), .addr(b_addr),
        .wdata(b_wdata), .rdata(b_rdata), .peer_mem(mem_a), .own_mem(mem_b)
    );
endmodule

// File: rtl/dual_aspect_bram_chk.sv
module dual_aspect_bram_chk #(
    parameter int A_WIDTH    = 36,
    parameter bit A_RISE     = 1'b1,
    parameter bit A_WE_HIGH  = 1'b1,
    parameter bit A_EN_HIGH  = 1'b1,
    parameter bit A_RST_HIGH = 1'b1,
    parameter int B_WIDTH    = 9,
    parameter bit B_RISE     = 1'b0,
    parameter bit B_WE_HIGH  = 1'b0,
    parameter bit B_EN_HIGH  = 1'b0,
    parameter bit B_RST_HIGH = 1'b1
) (
    input logic               a_clk,
    input logic               a_en,
    input logic               a_we,
    input logic               a_rst,
    input logic [A_WIDTH-1:0] a_wdata,
    input logic [A_WIDTH-1:0] a_rdata,
    input logic               b_clk,
    input logic               b_en,
    input logic               b_we,
    input logic               b_rst,
    input logic [B_WIDTH-1:0] b_wdata,
    input logic [B_WIDTH-1:0] b_rdata
);
    logic a_ck, b_ck;
    logic a_en_on, a_we_on, a_rst_on, b_en_on, b_we_on, b_rst_on;

    assign a_ck     = A_RISE ? a_clk : ~a_clk;
    assign b_ck     = B_RISE ? b_clk : ~b_clk;
    assign a_en_on  = (a_en == A_EN_HIGH);
    assign a_we_on  = (a_we == A_WE_HIGH);
    assign a_rst_on = (a_rst == A_RST_HIGH);
    assign b_en_on  = (b_en == B_EN_HIGH);
    assign b_we_on  = (b_we == B_WE_HIGH);
    assign b_rst_on = (b_rst == B_RST_HIGH);

    a_r4_a_reset_zero: assert property (@(posedge a_ck) disable iff ($isunknown(a_rst))
        a_rst_on |=> (a_rdata == '0));
    a_r4_b_reset_zero: assert property (@(posedge b_ck) disable iff ($isunknown(b_rst))
        b_rst_on |=> (b_rdata == '0));
    a_r5_a_hold: assert property (@(posedge a_ck) disable iff (a_rst_on)
        (!a_en_on && !a_rst_on) |=> $stable(a_rdata));
    a_r5_b_hold: assert property (@(posedge b_ck) disable iff (b_rst_on)
        (!b_en_on && !b_rst_on) |=> $stable(b_rdata));
    a_r6_a_write_first: assert property (@(posedge a_ck) disable iff (a_rst_on)
        (a_en_on && a_we_on) |=> (a_rdata == $past(a_wdata)));
    a_r6_b_write_first: assert property (@(posedge b_ck) disable iff (b_rst_on)
        (b_en_on && b_we_on) |=> (b_rdata == $past(b_wdata)));
endmodule

bind dual_aspect_bram dual_aspect_bram_chk #(
    .A_WIDTH(A_WIDTH), .A_RISE(A_RISE), .A_WE_HIGH(A_WE_HIGH),
    .A_EN_HIGH(A_EN_HIGH), .A_RST_HIGH(A_RST_HIGH),
    .B_WIDTH(B_WIDTH), .B_RISE(B_RISE), .B_WE_HIGH(B_WE_HIGH),
    .B_EN_HIGH(B_EN_HIGH), .B_RST_HIGH(B_RST_HIGH)
) i_chk (
    .a_clk(a_clk), .a_en(a_en), .a_we(a_we), .a_rst(a_rst),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_clk(b_clk), .b_en(b_en), .b_we(b_we), .b_rst(b_rst),
    .b_wdata(b_wdata), .b_rdata(b_rdata)
);

// File: tb/test_dual_aspect_bram.sv
module test_dual_aspect_bram;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        a_en, a_we, a_rst, b_en, b_we, b_rst;
    logic [8:0]  a_addr;
    logic [35:0] a_wdata, a_rdata;
    logic [10:0] b_addr;
    logic [8:0]  b_wdata, b_rdata;
    int          checks = 0;
    int          errors = 0;
    logic [35:0] held;

    always #(PERIOD/2) clk = ~clk;

    dual_aspect_bram i_dual_aspect_bram (
        .a_clk(clk), .a_en(a_en), .a_we(a_we), .a_rst(a_rst), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_clk(clk), .b_en(b_en), .b_we(b_we), .b_rst(b_rst), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    function automatic logic [35:0] pat_a(input int r);
        logic [31:0] d = (32'(r) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        return {4'(r) ^ 4'h9, d};
    endfunction

    function automatic logic [8:0] pat_b(input int b);
        return 9'(b * 37 + 11);
    endfunction

    // Port B word b = byte lane b%4 of row b/4, parity bit b%4 of that row.
    function automatic logic [8:0] exp_b_from_a(input int b);
        logic [35:0] w = pat_a(b / 4);
        int lane = b % 4;
        return {w[32 + lane], w[8*lane +: 8]};
    endfunction

    function automatic logic [35:0] exp_a_from_b(input int r);
        logic [35:0] w;
        for (int k = 0; k < 4; k++) begin
            logic [8:0] v = pat_b(4*r + k);
            w[8*k +: 8] = v[7:0];
            w[32 + k]   = v[8];
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Port A: rising edge, active-high controls. Drive at falling edge, sample after rising.
    task automatic a_op(input logic en, input logic we, input logic rst,
                        input int addr, input logic [35:0] wd);
        @(negedge clk);
        a_en = en; a_we = we; a_rst = rst; a_addr = 9'(addr); a_wdata = wd;
        @(posedge clk); #1;
        a_en = 1'b0; a_we = 1'b0; a_rst = 1'b0;
    endtask

    // Port B: falling edge, active-low enable and write enable, active-high reset.
    task automatic b_op(input logic en, input logic we, input logic rst,
                        input int addr, input logic [8:0] wd);
        @(posedge clk);
        b_en = en; b_we = we; b_rst = rst; b_addr = 11'(addr); b_wdata = wd;
        @(negedge clk); #1;
        b_en = 1'b1; b_we = 1'b1; b_rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Both output registers held in reset from time zero.
        a_en = 1'b1; a_we = 1'b0; a_rst = 1'b1; a_addr = '0; a_wdata = '0;
        b_en = 1'b0; b_we = 1'b1; b_rst = 1'b1; b_addr = '0; b_wdata = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R4 port A reset state", a_rdata, 36'h0);
        check("R4 port B reset state", {27'h0, b_rdata}, 36'h0);
        a_en = 1'b0; a_rst = 1'b0;
        @(negedge clk); #1;
        b_en = 1'b1; b_rst = 1'b0;

        // Fill through the 36-bit port; write-first shows each word.
        for (int r = 0; r < 512; r++) begin
            a_op(1'b1, 1'b1, 1'b0, r, pat_a(r));
            check("R6 port A write-first", a_rdata, pat_a(r));
        end
        // Read everything back through the 9-bit port.
        for (int b = 0; b < 2048; b++) begin
            b_op(1'b0, 1'b1, 1'b0, b, 9'h0);
            check("R1 R2 R3 R9 port B reads A data and parity", {27'h0, b_rdata},
                  {27'h0, exp_b_from_a(b)});
        end

        // Falling-edge port: no change across the rising edge before its edge.
        b_op(1'b0, 1'b1, 1'b0, 20, 9'h0);
        @(posedge clk);
        b_en = 1'b0; b_we = 1'b1; b_addr = 11'd21;
        #1;
        check("R7 port B stable across rising edge", {27'h0, b_rdata}, {27'h0, exp_b_from_a(20)});
        @(negedge clk); #1;
        check("R7 R9 port B updates on falling edge", {27'h0, b_rdata}, {27'h0, exp_b_from_a(21)});
        b_en = 1'b1;

        // Disabled port A ignores an active write enable and holds its output.
        a_op(1'b1, 1'b0, 1'b0, 2, 36'h0);
        held = a_rdata;
        a_op(1'b0, 1'b1, 1'b0, 3, 36'hF_FFFF_FFFF);
        check("R5 port A disabled holds output", a_rdata, held);
        a_op(1'b1, 1'b0, 1'b0, 3, 36'h0);
        check("R5 port A disabled write left memory", a_rdata, pat_a(3));

        // Port B polarity: write enable high is inactive, so this is a read.
        b_op(1'b0, 1'b1, 1'b0, 10, 9'h000);
        check("R8 port B inactive write enable reads", {27'h0, b_rdata}, {27'h0, exp_b_from_a(10)});
        // Enable high is inactive: write enable low has no effect, output holds.
        b_op(1'b1, 1'b0, 1'b0, 11, 9'h000);
        check("R8 R5 port B inactive enable holds", {27'h0, b_rdata}, {27'h0, exp_b_from_a(10)});
        b_op(1'b0, 1'b1, 1'b0, 11, 9'h000);
        check("R8 port B memory untouched when disabled", {27'h0, b_rdata},
              {27'h0, exp_b_from_a(11)});

        // Reset clears output even with enable inactive; memory is kept.
        b_op(1'b1, 1'b1, 1'b1, 12, 9'h0);
        check("R4 port B reset while disabled", {27'h0, b_rdata}, 36'h0);
        b_op(1'b0, 1'b1, 1'b0, 12, 9'h0);
        check("R4 port B memory kept after reset", {27'h0, b_rdata}, {27'h0, exp_b_from_a(12)});
        a_op(1'b1, 1'b0, 1'b1, 7, 36'h0);
        check("R4 port A reset clears output", a_rdata, 36'h0);
        a_op(1'b1, 1'b0, 1'b0, 7, 36'h0);
        check("R4 port A memory kept after reset", a_rdata, pat_a(7));

        // Refill through the 9-bit port, read back through the 36-bit port.
        for (int b = 0; b < 2048; b++) begin
            b_op(1'b0, 1'b0, 1'b0, b, pat_b(b));
            check("R6 R3 port B write-first", {27'h0, b_rdata}, {27'h0, pat_b(b)});
        end
        for (int r = 0; r < 512; r++) begin
            a_op(1'b1, 1'b0, 1'b0, r, 36'h0);
            check("R1 R2 R9 port A reads B data and parity", a_rdata, exp_a_from_b(r));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule